// File: doc/BRIEF.md
# Flow-Through Burst SRAM Front End

This block is the clocked address and control front end of a synchronous burst static RAM whose reads are flow-through. On each rising clock edge it decides whether to load a new external address, step through a 4-word burst, hold the current beat, or deselect. The upper address bits stay in a register, and the low two bits come from a 2-bit beat counter. A strap input selects interleaved order, where the start address is XORed with the counter, or linear order, where the start address is added to the counter modulo 4. The counter never changes the upper address bits.

There are two address strobes, and they differ. The processor strobe is honoured only when the master select is asserted, and it always begins a read. The controller strobe is honoured whatever the master select is. It samples the write enables, so it can begin a read, a write or a deselect. A write is either global, covering all byte lanes, or a byte write that covers the lanes whose lane enable is low. Read data comes straight from the addressed word with no output register, and an asynchronous output enable gates the driver flag.

A three-state machine holds the access kind. In ST_IDLE nothing is driven and nothing is written. In ST_READ the addressed word is presented. In ST_WRITE the input word is merged into the addressed word on every edge. The transitions are:
- LOAD_READ: either strobe, with the device selected and no write requested.
- LOAD_WRITE: the controller strobe, with the device selected and a write requested.
- DESELECT: either strobe, with the device not selected.
- STEP: advance low with no strobe. The state is kept and the counter steps.
- WAIT: advance high with no strobe. The state and the address are kept.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A controller-strobe edge that selects the device with no write requested enters ST_READ. After that edge, in the same clock cycle, `dout` shows the word at the loaded address and `dout_oe` is high while `out_en_n` is low.
- R2: When `out_en_n` is high, `dout_oe` is low. The change takes effect immediately and does not wait for a clock edge.
- R3: A processor-strobe edge while `sel_main_n` is low loads the address and begins a read. The write enables are ignored on that edge and no word changes.
- R4: A processor-strobe edge while `sel_main_n` is high is ignored. An active burst keeps following `advance_n`.
- R5: A controller-strobe edge loads the address whatever `advance_n` is. If the device is not selected (selected means `sel_main_n`=0, `sel_hi`=1 and `sel_lo_n`=0), the edge enters ST_IDLE: `dout_oe` goes low and no word is written.
- R6: When both strobes are low and `sel_main_n` is low, the processor strobe wins. The edge is a read even if the write enables are active.
- R7: With `order_il`=1, the beats use the start address with its low two bits XORed with 00, 01, 10 and 11 in that order.
- R8: With `order_il`=0, each beat adds 1 modulo 4 to the low two bits and wraps inside the 4-word block. The upper bits never change during a burst.
- R9: An edge with `advance_n` high and no strobe holds the beat. A read presents the same word again, and a write writes the same location again.
- R10: A controller-strobe edge with `wr_all_n` low begins a write of all four byte lanes. Lane i is `din[8i+7:8i]`.
- R11: With `wr_all_n` high and `wr_lanes_n` low, only the lanes whose `lane_wr_n[i]` is 0 are written. If all four bits are 1, the edge begins a read.
- R12: Each STEP or WAIT edge in ST_WRITE writes `din` to the beat address, using the lane mask captured at the load edge.
- R13: After reset the block is in ST_IDLE with `dout_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | External word address |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_main_n | input | 1 | Master select, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lanes_n | input | 1 | Byte write enable, active low |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| order_il | input | 1 | 1 selects interleaved order, 0 selects linear order |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_oe | output | 1 | High when `dout` is driven |

## Verification
The bench builds the block with ADDR_W=18, LANES=4 and LANE_W=8, but with MEM_AW=6. The 64-word array is therefore small enough for a bench-side copy, and every word the bench writes can be read back. With this size, bursts that start at each of the four offsets, in both orders, can be checked against the expected word beat by beat. The bench also checks that deselected, processor-started and all-lanes-off writes leave words untouched. Partial-lane merges and held write beats are checked through later reads.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } sbs_state_e;

    // Low two address bits for a beat, from start offset and beat count
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       il);
        beat_lo = il ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 18,
    parameter int MEM_AW = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [MEM_AW-1:0] wr_idx;
    logic [MEM_AW-1:0] rd_idx;

    assign wr_idx = MEM_AW'(wr_addr % ADDR_W'(DEPTH));
    assign rd_idx = MEM_AW'(rd_addr % ADDR_W'(DEPTH));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_mask[g]) begin
                store[wr_idx] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = store[rd_idx];
    end

endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    localparam int UP_W = ADDR_W - 2;

    logic [UP_W-1:0] upper_q;
    logic [1:0]      start_q;
    logic [1:0]      cnt_q;
    logic [1:0]      cnt_inc;

    assign cnt_inc = cnt_q + 2'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:2];
            start_q <= addr_in[1:0];
            cnt_q   <= '0;
        end else if (step) begin
            cnt_q   <= cnt_inc;
        end
    end

    always_comb begin
        cur_addr = {upper_q, beat_lo(start_q, cnt_q, order_il)};
        if (load) begin
            nxt_addr = addr_in;
        end else if (step) begin
            nxt_addr = {upper_q, beat_lo(start_q, cnt_inc, order_il)};
        end else begin
            nxt_addr = cur_addr;
        end
    end

endmodule

// File: rtl/sbs_fsm.sv
module sbs_fsm
    import sbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proc_take,
    input  logic       ctrl_load,
    input  logic       sel_ok,
    input  logic       wr_req,
    input  logic       advance_n,
    output sbs_state_e state,
    output logic       load,
    output logic       step,
    output logic       mem_we,
    output logic       rd_drive
);
    sbs_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (proc_take) begin
            nxt = sel_ok ? ST_READ : ST_IDLE;
        end else if (ctrl_load) begin
            if (!sel_ok)     nxt = ST_IDLE;
            else if (wr_req) nxt = ST_WRITE;
            else             nxt = ST_READ;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_READ:  nxt = ST_READ;
                ST_WRITE: nxt = ST_WRITE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load     = proc_take || ctrl_load;
        step     = !load && (state != ST_IDLE) && !advance_n;
        mem_we   = (nxt == ST_WRITE);
        rd_drive = (state == ST_READ);
    end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int MEM_AW = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    proc_strobe_n,
    input  logic                    ctrl_strobe_n,
    input  logic                    advance_n,
    input  logic                    sel_main_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    wr_all_n,
    input  logic                    wr_lanes_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    input  logic                    order_il,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    localparam int DATA_W = LANES * LANE_W;

    logic              sel_ok, proc_take, ctrl_load, wr_req;
    logic [LANES-1:0]  new_mask, mask_q, mask_now;
    logic              load, step, mem_we, rd_drive;
    sbs_state_e        state;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;
    logic [DATA_W-1:0] rd_word;

    assign sel_ok    = !sel_main_n && sel_hi && !sel_lo_n;
    assign proc_take = !proc_strobe_n && !sel_main_n;
    assign ctrl_load = !ctrl_strobe_n && !proc_take;
    assign wr_req    = !wr_all_n || (!wr_lanes_n && (lane_wr_n != '1));

    always_comb begin
        if (!wr_all_n)       new_mask = '1;
        else if (!wr_lanes_n) new_mask = ~lane_wr_n;
        else                 new_mask = '0;
        mask_now = ctrl_load ? new_mask : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (ctrl_load) mask_q <= new_mask;
    end

    sbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .proc_take (proc_take),
        .ctrl_load (ctrl_load),
        .sel_ok    (sel_ok),
        .wr_req    (wr_req),
        .advance_n (advance_n),
        .state     (state),
        .load      (load),
        .step      (step),
        .mem_we    (mem_we),
        .rd_drive  (rd_drive)
    );

    sbs_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .order_il (order_il),
        .addr_in  (addr_i),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    sbs_array #(
        .ADDR_W (ADDR_W),
        .MEM_AW (MEM_AW),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk       (clk),
        .we        (mem_we),
        .lane_mask (mask_now),
        .wr_addr   (nxt_addr),
        .wdata     (din),
        .rd_addr   (cur_addr),
        .rdata     (rd_word)
    );

    assign dout    = rd_word;
    assign dout_oe = rd_drive && !out_en_n;

endmodule

// File: rtl/burst_sram_ctrl_chk.sv
module burst_sram_ctrl_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              advance_n,
    input logic              sel_main_n,
    input logic              sel_hi,
    input logic              sel_lo_n,
    input logic              out_en_n,
    input logic              dout_oe,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              mem_we
);
    logic sel_c;
    logic ptake_c;
    assign sel_c   = !sel_main_n && sel_hi && !sel_lo_n;
    assign ptake_c = !proc_strobe_n && !sel_main_n;

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dout_oe);  // R2
    AST_PROC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ptake_c |-> !mem_we);  // R3
    AST_PROC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && sel_main_n && ctrl_strobe_n && advance_n) |=> $stable(cur_addr));  // R4
    AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && !ptake_c) |=> (cur_addr == $past(addr_i)));  // R5
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && !ptake_c && !sel_c) |=> !dout_oe);  // R5
    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && !ptake_c && !sel_c) |-> !mem_we);  // R5
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && ctrl_strobe_n && !advance_n) |=> $stable(cur_addr[ADDR_W-1:2]));  // R8
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && ctrl_strobe_n && advance_n) |=> $stable(cur_addr));  // R9

endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_i        (addr_i),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .advance_n     (advance_n),
    .sel_main_n    (sel_main_n),
    .sel_hi        (sel_hi),
    .sel_lo_n      (sel_lo_n),
    .out_en_n      (out_en_n),
    .dout_oe       (dout_oe),
    .cur_addr      (cur_addr),
    .mem_we        (mem_we)
);

// File: tb/burst_sram_ctrl_bench.sv
module burst_sram_ctrl_bench;
    localparam int AW = 18;
    localparam int MAW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] a = '0;
    logic        p_n = 1, c_n = 1, adv_n = 1;
    logic        s_main_n = 0, s_hi = 1, s_lo_n = 0;
    logic        gw_n = 1, bw_n = 1;
    logic [3:0]  lanes_n = 4'hF;
    logic        oe_n = 0, ord = 1;
    logic [31:0] d = '0;
    logic [31:0] dout;
    logic        dout_oe;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] ref_mem [64];
    logic [15:0] m_up = '0;
    logic [1:0]  m_lo = '0, m_cnt = '0;
    int          m_st = 0;
    logic [3:0]  m_mask = '0;

    logic        q_oe [$];
    logic [31:0] q_dat [$];
    string       q_tag [$];

    always #5 clk = ~clk;

    burst_sram_ctrl #(.ADDR_W(AW), .MEM_AW(MAW), .LANES(4), .LANE_W(8)) u_burst_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(a), .proc_strobe_n(p_n), .ctrl_strobe_n(c_n),
        .advance_n(adv_n), .sel_main_n(s_main_n), .sel_hi(s_hi), .sel_lo_n(s_lo_n),
        .wr_all_n(gw_n), .wr_lanes_n(bw_n), .lane_wr_n(lanes_n), .out_en_n(oe_n),
        .order_il(ord), .din(d), .dout(dout), .dout_oe(dout_oe));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic dflt();
        p_n = 1; c_n = 1; adv_n = 1; s_main_n = 0; s_hi = 1; s_lo_n = 0;
        gw_n = 1; bw_n = 1; lanes_n = 4'hF; oe_n = 0; d = '0; a = '0;
    endtask

    // Driver: applies one edge, predicts from the requirements, queues the expectation
    task automatic tick(input string tag);
        logic sel, wr;
        logic [1:0] lo;
        int idx;
        @(posedge clk);
        sel = !s_main_n && s_hi && !s_lo_n;
        if (!p_n && !s_main_n) begin
            m_up = a[17:2]; m_lo = a[1:0]; m_cnt = 0; m_st = sel ? 1 : 0;
        end else if (!c_n) begin
            wr = !gw_n || (!bw_n && lanes_n != 4'hF);
            m_mask = !gw_n ? 4'hF : (!bw_n ? ~lanes_n : 4'h0);
            m_up = a[17:2]; m_lo = a[1:0]; m_cnt = 0;
            m_st = sel ? (wr ? 2 : 1) : 0;
        end else if (m_st != 0 && !adv_n) begin
            m_cnt = m_cnt + 2'd1;
        end
        lo  = ord ? (m_lo ^ m_cnt) : (m_lo + m_cnt);
        idx = int'({m_up[3:0], lo});
        if (m_st == 2)
            for (int i = 0; i < 4; i++)
                if (m_mask[i]) ref_mem[idx][8*i +: 8] = d[8*i +: 8];
        q_oe.push_back((m_st == 1) && !oe_n);
        q_dat.push_back(ref_mem[idx]);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: pops one expectation per edge, samples after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_oe.size() > 0) begin
                logic eo; logic [31:0] ed; string et;
                eo = q_oe.pop_front(); ed = q_dat.pop_front(); et = q_tag.pop_front();
                check({et, " oe"}, {31'd0, dout_oe}, {31'd0, eo});
                if (eo) check({et, " data"}, dout, ed);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        dflt();
        repeat (3) @(negedge clk);
        check("R13 reset", {31'd0, dout_oe}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R13 idle", {31'd0, dout_oe}, 32'd0);

        // Fill words 0..15 with global write bursts, varied start offsets (interleaved)
        for (int b = 0; b < 4; b++) begin
            dflt(); c_n = 0; gw_n = 0; a = AW'(b*4 + b); d = 32'hA000_0000 + 32'(b*16);
            tick("R10");
            for (int k = 1; k < 4; k++) begin
                dflt(); adv_n = 0; d = 32'hA000_0000 + 32'(b*16 + k);
                tick("R12");
            end
        end

        // Interleaved read from offset 1: 1,0,3,2
        dflt(); c_n = 0; adv_n = 0; a = 18'd1; tick("R1");
        dflt(); adv_n = 0; tick("R7");
        dflt(); tick("R9");
        // Asynchronous output enable
        oe_n = 1; #1;
        check("R2 async off", {31'd0, dout_oe}, 32'd0);
        oe_n = 0; #1;
        check("R2 async on", {31'd0, dout_oe}, 32'd1);
        dflt(); adv_n = 0; tick("R7");
        dflt(); adv_n = 0; tick("R7");

        // Deselect via controller strobe with a write request
        dflt(); c_n = 0; s_hi = 0; gw_n = 0; d = 32'hDEAD_BEEF; a = 18'd2; tick("R5");
        dflt(); adv_n = 0; tick("R5");

        // Linear, processor strobe with global write driven (ignored)
        ord = 0;
        dflt(); p_n = 0; gw_n = 0; d = 32'h1111_1111; a = 18'd6; tick("R3");
        dflt(); adv_n = 0; tick("R8");
        dflt(); p_n = 0; s_main_n = 1; adv_n = 0; a = 18'h20; tick("R4");
        dflt(); adv_n = 0; tick("R8");
        dflt(); adv_n = 0; tick("R8");

        // Both strobes low: processor wins, read
        dflt(); p_n = 0; c_n = 0; gw_n = 0; d = 32'h2222_2222; a = 18'd13; tick("R6");
        for (int k = 0; k < 3; k++) begin dflt(); adv_n = 0; tick("R6"); end

        // Byte write lanes 0 and 2, then a held write beat
        dflt(); c_n = 0; bw_n = 0; lanes_n = 4'b1010; d = 32'hFFFF_FFFF; a = 18'd9; tick("R11");
        dflt(); d = 32'h1234_5678; tick("R9");
        dflt(); c_n = 0; a = 18'd9; tick("R11");
        // Byte write enable with no lane selected -> read
        dflt(); c_n = 0; bw_n = 0; a = 18'd8; tick("R11");
        dflt(); adv_n = 0; tick("R11");

        // Processor strobe with secondary select off: deselect
        dflt(); p_n = 0; s_hi = 0; a = 18'd3; tick("R5");
        // Read back word 2 and word 6: untouched
        dflt(); c_n = 0; a = 18'd2; tick("R5");
        dflt(); c_n = 0; a = 18'd6; tick("R3");
        dflt(); tick("R9");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule